// File: doc/BRIEF.md
# Strap-Keyed Configuration Access Controller

This block guards a small bank of configuration registers behind a key sequence written by the host. Two strap pins, sampled continuously, choose where the key must be written, which key byte is accepted and how many times in a row it must arrive. Once the key sequence is complete the host selects a register through an index address and reads or writes it through a data address. Both addresses move with the entry address. Writing the exit code to the entry address locks the bank again.

The bank holds a parallel-port base address stored divided by four, a read-only chip identifier, read-back copies of the two straps, and a three-bit port-mode selector split across two registers. From these the block drives the decoded base address, the mode and an enable for the parallel-port address decode. Host reads are registered and return 0xFF wherever the bank cannot be reached.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: After synchronous reset the bank is locked, `bus_rdata` is 0xFF, `pp_mode` is 0, `pp_base` is 0 and `pp_decode_en` is low.
- R2: The key depends on {`strap_hi_addr`,`strap_key_sel`}: 00 needs 0x88 written once to 0x250, 01 needs 0x89 written once to 0x250, 10 needs 0x86 written twice in a row to 0x3F0, 11 needs 0x87 written twice in a row to 0x3F0. A single write where two are needed leaves the bank locked.
- R3: While locked, any byte other than the key written to the entry address discards the partial match, so the full count of key writes is needed afterwards.
- R4: When unlocked, with `strap_hi_addr`=0 the index is at 0x251 and data at 0x252; with `strap_hi_addr`=1 the index is at 0x3F0 and data at 0x3F1. A read of the index address returns the current index; a read of the data address returns the selected register.
- R5: While locked, reads of the index and data addresses return 0xFF, and writes to them change no register and no output.
- R6: When unlocked, 0xAA written to the entry address locks the bank and, where entry and index share 0x3F0, does not change the index. With `strap_hi_addr`=0, 0xAA written to 0x251 is only an index write.
- R7: Register 0x0C reads `strap_key_sel` in bit 5 and register 0x16 reads `strap_hi_addr` in bit 0; all other bits read 0 and writes have no effect.
- R8: Register 0x09 bits 3:0 read the `CHIP_ID` parameter and ignore writes; bits 7:4 are writable.
- R9: Register 0x23 is writable and `pp_base` equals its value times four.
- R10: `pp_mode` is {reg 0x09 bit 5, reg 0x00 bits 1:0}; codes 0-3 select non-parallel functions, 4 a legacy mode, 5 EPP+SPP, 6 ECP, 7 ECP+EPP. `pp_decode_en` is high only for codes 5, 6, 7 with register 0x23 non-zero.
- R11: Registers other than 0x00, 0x09, 0x0C, 0x16 and 0x23 read 0x00 and ignore writes; register 0x00 stores all eight bits.
- R12: `bus_rdata` takes the value for a read one clock after `bus_rd` is sampled high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hi_addr | input | 1 | Strap choosing the high (0x3F0) or low (0x250) access window |
| strap_key_sel | input | 1 | Strap choosing the key byte within the window |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 10 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| pp_base | output | 10 | Decoded parallel-port base address |
| pp_mode | output | 3 | Port-mode code |
| pp_decode_en | output | 1 | Parallel-port address decode enable |

## Verification
In the high window the exit command and an index write land on the same address, so one bus write at 0x3F0 could both lock the bank and move the index. The bench selects a known register, writes 0xAA to 0x3F0, checks the data address then reads 0xFF, unlocks again and reads the index address to confirm it still holds the earlier index rather than 0xAA. In the low window the same byte sent to the index address must leave the bank open, which the bench judges by reading the index back as 0xAA.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 8;
    localparam int ID_W       = 4;
    localparam int REP_W      = 2;
    localparam int BASE_SHIFT = 2;
    localparam int BASE_W     = DATA_W + BASE_SHIFT;
    localparam int MODE_W     = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        byte_t data;
    } bus_req_t;

    typedef enum logic [MODE_W-1:0] {
        PM_FLOPPY_EXT = 3'b000,
        PM_ADAPTER    = 3'b001,
        PM_DUAL_FDD   = 3'b010,
        PM_GAME       = 3'b011,
        PM_LEGACY     = 3'b100,
        PM_EPP_SPP    = 3'b101,
        PM_ECP        = 3'b110,
        PM_ECP_EPP    = 3'b111
    } port_mode_e;

    localparam addr_t LOW_ENTRY  = 10'h250;
    localparam addr_t LOW_INDEX  = 10'h251;
    localparam addr_t LOW_DATA   = 10'h252;
    localparam addr_t HIGH_ENTRY = 10'h3F0;
    localparam addr_t HIGH_INDEX = 10'h3F0;
    localparam addr_t HIGH_DATA  = 10'h3F1;

    localparam byte_t EXIT_CODE  = 8'hAA;
    localparam byte_t LOCKED_VAL = 8'hFF;

    localparam byte_t IDX_MODE   = 8'h00;
    localparam byte_t IDX_IDENT  = 8'h09;
    localparam byte_t IDX_KSTRAP = 8'h0C;
    localparam byte_t IDX_ASTRAP = 8'h16;
    localparam byte_t IDX_BASE   = 8'h23;

    localparam int KSTRAP_BIT  = 5;
    localparam int ASTRAP_BIT  = 0;
    localparam int MODE_HI_BIT = 5;

    function automatic addr_t entry_addr(input logic hi);
        return hi ? HIGH_ENTRY : LOW_ENTRY;
    endfunction

    function automatic addr_t index_addr(input logic hi);
        return hi ? HIGH_INDEX : LOW_INDEX;
    endfunction

    function automatic addr_t data_addr(input logic hi);
        return hi ? HIGH_DATA : LOW_DATA;
    endfunction

    function automatic byte_t unlock_key(input logic hi, input logic ks);
        case ({hi, ks})
            2'b01:   return 8'h89;
            2'b10:   return 8'h86;
            2'b11:   return 8'h87;
            default: return 8'h88;
        endcase
    endfunction

    function automatic logic [REP_W-1:0] unlock_reps(input logic hi);
        return hi ? REP_W'(2) : REP_W'(1);
    endfunction

    function automatic logic mode_is_parallel(input port_mode_e m);
        return (m == PM_EPP_SPP) || (m == PM_ECP) || (m == PM_ECP_EPP);
    endfunction

endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
    import cfg_unlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hi_sel,
    input  logic     key_sel,
    input  bus_req_t req,
    output logic     unlocked
);
    logic [REP_W-1:0] match_cnt;
    logic [REP_W-1:0] cnt_next;
    logic             entry_wr;
    logic             key_ok;

    assign entry_wr = req.wr && (req.addr == entry_addr(hi_sel));
    assign key_ok   = (req.data == unlock_key(hi_sel, key_sel));
    assign cnt_next = match_cnt + REP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked  <= 1'b0;
            match_cnt <= '0;
        end else if (!unlocked) begin
            if (entry_wr) begin
                if (!key_ok) begin
                    match_cnt <= '0;
                end else if (cnt_next == unlock_reps(hi_sel)) begin
                    unlocked  <= 1'b1;
                    match_cnt <= '0;
                end else begin
                    match_cnt <= cnt_next;
                end
            end
        end else if (entry_wr && (req.data == EXIT_CODE)) begin
            unlocked  <= 1'b0;
            match_cnt <= '0;
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_unlock_pkg::*;
#(
    parameter logic [ID_W-1:0] CHIP_ID = 4'hA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  byte_t             wdata,
    input  logic              hi_sel,
    input  logic              key_sel,
    output byte_t             index_q,
    output byte_t             sel_val,
    output port_mode_e        mode_code,
    output byte_t             base_div4
);
    localparam int HI_NIB_W = DATA_W - ID_W;

    byte_t               r_mode;
    logic [HI_NIB_W-1:0] r_ident_hi;
    byte_t               r_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q    <= '0;
            r_mode     <= '0;
            r_ident_hi <= '0;
            r_base     <= '0;
        end else begin
            if (idx_wr) begin
                index_q <= wdata;
            end
            if (dat_wr) begin
                case (index_q)
                    IDX_MODE:  r_mode     <= wdata;
                    IDX_IDENT: r_ident_hi <= wdata[DATA_W-1:ID_W];
                    IDX_BASE:  r_base     <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        sel_val = '0;
        case (index_q)
            IDX_MODE:   sel_val = r_mode;
            IDX_IDENT:  sel_val = {r_ident_hi, CHIP_ID};
            IDX_KSTRAP: sel_val[KSTRAP_BIT] = key_sel;
            IDX_ASTRAP: sel_val[ASTRAP_BIT] = hi_sel;
            IDX_BASE:   sel_val = r_base;
            default:    sel_val = '0;
        endcase
    end

    assign mode_code = port_mode_e'({r_ident_hi[MODE_HI_BIT-ID_W], r_mode[1:0]});
    assign base_div4 = r_base;
endmodule

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfg_unlock_pkg::*;
(
    input  port_mode_e        mode_code,
    input  byte_t             base_div4,
    output logic [BASE_W-1:0] port_base,
    output logic [MODE_W-1:0] port_mode,
    output logic              decode_en
);
    assign port_base = {base_div4, {BASE_SHIFT{1'b0}}};
    assign port_mode = mode_code;
    assign decode_en = mode_is_parallel(mode_code) && (base_div4 != '0);
endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
    import cfg_unlock_pkg::*;
#(
    parameter logic [ID_W-1:0] CHIP_ID = 4'hA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_hi_addr,
    input  logic              strap_key_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BASE_W-1:0] pp_base,
    output logic [MODE_W-1:0] pp_mode,
    output logic              pp_decode_en
);
    bus_req_t   req;
    logic       unlocked;
    logic       exit_hit;
    logic       idx_wr;
    logic       dat_wr;
    byte_t      index_q;
    byte_t      sel_val;
    port_mode_e mode_code;
    byte_t      base_div4;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};

    cfg_key_seq u_key (
        .clk      (clk),
        .rst      (rst),
        .hi_sel   (strap_hi_addr),
        .key_sel  (strap_key_sel),
        .req      (req),
        .unlocked (unlocked)
    );

    // exit takes priority over an index write on a shared address
    assign exit_hit = req.wr && (req.addr == entry_addr(strap_hi_addr))
                      && (req.data == EXIT_CODE);
    assign idx_wr   = unlocked && req.wr && !exit_hit
                      && (req.addr == index_addr(strap_hi_addr));
    assign dat_wr   = unlocked && req.wr
                      && (req.addr == data_addr(strap_hi_addr));

    cfg_reg_bank #(.CHIP_ID(CHIP_ID)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .wdata     (req.data),
        .hi_sel    (strap_hi_addr),
        .key_sel   (strap_key_sel),
        .index_q   (index_q),
        .sel_val   (sel_val),
        .mode_code (mode_code),
        .base_div4 (base_div4)
    );

    cfg_port_decode u_dec (
        .mode_code (mode_code),
        .base_div4 (base_div4),
        .port_base (pp_base),
        .port_mode (pp_mode),
        .decode_en (pp_decode_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= LOCKED_VAL;
        end else if (req.rd) begin
            if (unlocked && (req.addr == data_addr(strap_hi_addr))) begin
                bus_rdata <= sel_val;
            end else if (unlocked && (req.addr == index_addr(strap_hi_addr))) begin
                bus_rdata <= index_q;
            end else begin
                bus_rdata <= LOCKED_VAL;
            end
        end
    end
endmodule

// File: rtl/cfg_unlock_ctrl_chk.sv
module cfg_unlock_ctrl_chk
    import cfg_unlock_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              strap_hi_addr,
    input logic              strap_key_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [BASE_W-1:0] pp_base,
    input logic [MODE_W-1:0] pp_mode,
    input logic              pp_decode_en,
    input logic              unlocked
);
    p_locked_read_ff_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !unlocked) |=> (bus_rdata == LOCKED_VAL));

    p_locked_cfg_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ($stable(pp_mode) && $stable(pp_base)));

    p_exit_locks_r6: assert property (@(posedge clk) disable iff (rst)
        (unlocked && bus_wr && (bus_addr == entry_addr(strap_hi_addr))
         && (bus_wdata == EXIT_CODE)) |=> !unlocked);

    p_unlock_on_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(bus_wr)
            && ($past(bus_addr) == entry_addr($past(strap_hi_addr)))
            && ($past(bus_wdata) == unlock_key($past(strap_hi_addr), $past(strap_key_sel)))));

    p_decode_needs_base_r10: assert property (@(posedge clk) disable iff (rst)
        pp_decode_en |-> ((pp_base != '0) && (pp_mode >= 3'd5)));
endmodule

bind cfg_unlock_ctrl cfg_unlock_ctrl_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .strap_hi_addr (strap_hi_addr),
    .strap_key_sel (strap_key_sel),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .pp_base       (pp_base),
    .pp_mode       (pp_mode),
    .pp_decode_en  (pp_decode_en),
    .unlocked      (unlocked)
);

// File: tb/cfg_unlock_ctrl_tb_top.sv
module cfg_unlock_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] TB_CHIP_ID = 4'hA;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_hi_addr = 1'b0;
    logic       strap_key_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [9:0] pp_base;
    logic [2:0] pp_mode;
    logic       pp_decode_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_mode, m_base, m_idx;
    logic [3:0] m_idhi;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_unlock_ctrl #(.CHIP_ID(TB_CHIP_ID)) dut_i (
        .clk(clk), .rst(rst), .strap_hi_addr(strap_hi_addr),
        .strap_key_sel(strap_key_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pp_base(pp_base), .pp_mode(pp_mode), .pp_decode_en(pp_decode_en)
    );

    function automatic logic [9:0] f_entry(input logic hi);
        return hi ? 10'h3F0 : 10'h250;
    endfunction
    function automatic logic [9:0] f_index(input logic hi);
        return hi ? 10'h3F0 : 10'h251;
    endfunction
    function automatic logic [9:0] f_data(input logic hi);
        return hi ? 10'h3F1 : 10'h252;
    endfunction
    function automatic logic [7:0] f_key(input logic hi, input logic ks);
        if (!hi) return ks ? 8'h89 : 8'h88;
        return ks ? 8'h87 : 8'h86;
    endfunction
    function automatic int f_reps(input logic hi);
        return hi ? 2 : 1;
    endfunction
    function automatic logic [7:0] f_reg(input logic [7:0] i);
        case (i)
            8'h00: return m_mode;
            8'h09: return {m_idhi, TB_CHIP_ID};
            8'h0C: return {2'b00, strap_key_sel, 5'b0};
            8'h16: return {7'b0, strap_hi_addr};
            8'h23: return m_base;
            default: return 8'h00;
        endcase
    endfunction
    function automatic logic [2:0] f_mode();
        return {m_idhi[1], m_mode[1:0]};
    endfunction
    function automatic logic f_dec();
        logic [2:0] m;
        m = f_mode();
        return (m == 3'd5 || m == 3'd6 || m == 3'd7) && (m_base != 8'h00);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic model_write(input logic [7:0] d);
        case (m_idx)
            8'h00: m_mode = d;
            8'h09: m_idhi = d[7:4];
            8'h23: m_base = d;
            default: ;
        endcase
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        bwr(f_index(strap_hi_addr), i);
        m_idx = i;
        bwr(f_data(strap_hi_addr), d);
        model_write(d);
    endtask

    task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
        bwr(f_index(strap_hi_addr), i);
        m_idx = i;
        brd(f_data(strap_hi_addr), d);
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " pp_mode"}, 16'(pp_mode), 16'(f_mode()));
        chk({req, " pp_base"}, 16'(pp_base), 16'({m_base, 2'b00}));
        chk({req, " pp_decode_en"}, 16'(pp_decode_en), 16'(f_dec()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] key;
        logic [9:0] da;
        void'($urandom(32'd4177));
        for (int s = 0; s < 4; s++) begin
            strap_hi_addr = s[1];
            strap_key_sel = s[0];
            key = f_key(strap_hi_addr, strap_key_sel);
            da  = f_data(strap_hi_addr);
            rst = 1'b1;
            m_mode = 0; m_base = 0; m_idhi = 0; m_idx = 0;
            repeat (3) @(negedge clk);
            rst = 1'b0;
            // R1 reset state
            chk("R1 rdata", 16'(bus_rdata), 16'hFF);
            chk("R1 pp_mode", 16'(pp_mode), 16'h0);
            chk("R1 pp_base", 16'(pp_base), 16'h0);
            chk("R1 pp_decode_en", 16'(pp_decode_en), 16'h0);

            // R5 locked accesses ignored
            bwr(f_index(strap_hi_addr), 8'h23);
            bwr(da, 8'h5A);
            brd(da, rv);
            chk("R5 locked data read", 16'(rv), 16'hFF);
            brd(f_index(strap_hi_addr), rv);
            chk("R5 locked index read", 16'(rv), 16'hFF);
            chk("R5 locked write base", 16'(pp_base), 16'h0);

            // R2 / R3 key sequence
            if (f_reps(strap_hi_addr) == 2) begin
                bwr(f_entry(strap_hi_addr), key);
                brd(da, rv);
                chk("R2 single key insufficient", 16'(rv), 16'hFF);
                bwr(f_entry(strap_hi_addr), 8'h00);
                bwr(f_entry(strap_hi_addr), key);
                brd(da, rv);
                chk("R3 partial match cleared", 16'(rv), 16'hFF);
                bwr(f_entry(strap_hi_addr), key);
            end else begin
                bwr(f_entry(strap_hi_addr), key ^ 8'h01);
                brd(da, rv);
                chk("R3 wrong key stays locked", 16'(rv), 16'hFF);
                bwr(f_entry(strap_hi_addr), 8'h86 ^ key ^ 8'h86 ^ 8'h0F);
                bwr(f_entry(strap_hi_addr), key);
            end

            // R7 strap readback, read-only
            reg_wr(8'h16, 8'hFF);
            reg_rd(8'h16, rv);
            chk("R2 R7 unlocked, addr strap bit", 16'(rv), 16'(f_reg(8'h16)));
            reg_wr(8'h0C, 8'hFF);
            reg_rd(8'h0C, rv);
            chk("R7 key strap bit", 16'(rv), 16'(f_reg(8'h0C)));

            // R8 chip id
            reg_wr(8'h09, 8'hF3);
            reg_rd(8'h09, rv);
            chk("R8 ident", 16'(rv), 16'(f_reg(8'h09)));
            reg_wr(8'h09, 8'h00);

            // R11 unimplemented
            reg_wr(8'h40, 8'h77);
            reg_rd(8'h40, rv);
            chk("R11 unimplemented reads zero", 16'(rv), 16'h00);
            chk_outputs("R11");

            // R10 every mode code, base zero then non-zero
            for (int m = 0; m < 8; m++) begin
                reg_wr(8'h23, 8'h00);
                reg_wr(8'h00, {6'b0, m[1:0]});
                reg_wr(8'h09, {2'b00, m[2], 5'b0});
                chk_outputs("R10 base zero");
                reg_wr(8'h23, 8'h9E);
                chk_outputs("R10 R9 base set");
            end

            // random register traffic
            for (int k = 0; k < 40; k++) begin
                logic [7:0] idx, d;
                case ($urandom % 6)
                    0: idx = 8'h00;
                    1: idx = 8'h09;
                    2: idx = 8'h23;
                    3: idx = 8'h0C;
                    4: idx = 8'h16;
                    default: idx = 8'($urandom);
                endcase
                if (idx == 8'hAA) idx = 8'h55;
                d = 8'($urandom);
                reg_wr(idx, d);
                chk_outputs("R9 R10 random");
                brd(da, rv);
                chk("R4 R12 readback", 16'(rv), 16'(f_reg(idx)));
                brd(f_index(strap_hi_addr), rv);
                chk("R4 index readback", 16'(rv), 16'(idx));
            end

            // R6 exit behaviour
            reg_rd(8'h23, rv);
            if (!strap_hi_addr) begin
                bwr(f_index(strap_hi_addr), 8'hAA);
                brd(f_index(strap_hi_addr), rv);
                chk("R6 0xAA to index is index write", 16'(rv), 16'hAA);
                bwr(f_index(strap_hi_addr), 8'h23);
            end
            bwr(f_entry(strap_hi_addr), 8'hAA);
            brd(da, rv);
            chk("R6 exit locks", 16'(rv), 16'hFF);
            bwr(f_index(strap_hi_addr), 8'h00);
            bwr(da, 8'h00);
            chk_outputs("R5 R6 locked after exit");
            for (int r = 0; r < f_reps(strap_hi_addr); r++)
                bwr(f_entry(strap_hi_addr), key);
            brd(f_index(strap_hi_addr), rv);
            chk("R6 index kept across exit", 16'(rv), 16'h23);
            bwr(f_entry(strap_hi_addr), 8'hAA);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule